// File: doc/BRIEF.md
# Transmit Checksum Insertion Engine

The engine sits in a transmit path between a frame source and a MAC. For each frame, software first hands it a five-word sideband control header. The header says whether a 16-bit ones'-complement checksum is wanted, where summing starts, where the result goes, and what seed to add. The frame then arrives as a byte stream and is stored whole in an internal buffer. Storing the whole frame first lets the checksum land at a position that comes before the end of the summed region, for example inside a transport header. The frame is then replayed on the output stream with the two checksum bytes overwritten.

Frame-level policy also lives here. A transmit enable can make the engine swallow frames. A length rule drops frames that are slightly over the standard size unless jumbo or tagged frames are allowed. Every frame that is sent raises a one-cycle completion pulse and adds its length to a 64-bit byte counter.

The control follows one state machine:
- **IDLE** accepts header words. Its first data byte goes to FILL, or to SKIP when transmit is disabled.
- **FILL** stores and sums bytes until the last byte, then goes to FOLD.
- **SKIP** discards bytes until the last byte, then returns to IDLE.
- **FOLD** applies the length rule. It either drops the frame and returns to IDLE, or latches the folded checksum and goes to SEND.
- **SEND** replays the buffer and returns to IDLE after the final output handshake.

Top module: `txcs_engine`

## Requirements
- R1: A header is valid only when `hdr_last` comes with its fifth word. A header ended at any other word count is rejected. `hdr_err` then pulses for one cycle, in the cycle after that last word, and the next frame is sent without insertion.
- R2: Header field positions:
  - Word 0 bit 0 turns insertion on.
  - Word 1 bits 31:16 give the byte offset where summing starts.
  - Word 1 bits 15:0 give the byte offset where the result is written.
  - Word 2 bits 15:0 give a seed that is added into the sum.
- R3: Summing treats the bytes from the start offset as big-endian 16-bit pairs. A lone last byte counts as the high half, with a zero low half. The seed is added, carries are folded back until 16 bits remain, and the result is inverted. A zero result is written as 0x0000.
- R4: The high byte of the result replaces the byte at the insertion offset, and the low byte replaces the one after it. A position past the frame end is not written. The sum always uses the bytes as they were received.
- R5: A header applies to one frame only. A frame with no valid header since the previous frame leaves the engine unchanged.
- R6: If `tx_en` is low when a frame's first byte is accepted, the whole frame is consumed. Nothing is output, `tx_done` stays low and `tx_bytes` is unchanged.
- R7: With `jumbo_en` and `vlan_en` both low, a frame of 1519 to 1522 bytes is dropped silently. If either enable is high, such a frame is sent. Frames of 1518 bytes or less, and of 1523 bytes or more, are always sent.
- R8: Each frame that is sent pulses `tx_done` for one cycle. The pulse comes in the cycle after the handshake on the output byte with `m_tlast`. `tx_bytes` grows by the frame length at the same edge.
- R9: `m_tvalid` first rises two cycles after the edge that accepts the input byte with `s_tlast`. While `m_tready` is low, `m_tdata` and `m_tlast` hold. `s_tready` is never high while `m_tvalid` is high.
- R10: A frame longer than `BUF_DEPTH` bytes is cut to its first `BUF_DEPTH` bytes. The rest are consumed and discarded.
- R11: After reset the engine is in IDLE:
  - `m_tvalid`, `tx_done` and `hdr_err` are low.
  - `tx_bytes` is 0.
  - `hdr_ready` is high.
  - `s_tready` is high while `hdr_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header word valid |
| hdr_ready | output | 1 | Header word accepted (IDLE only) |
| hdr_data | input | 32 | Header word |
| hdr_last | input | 1 | Final header word |
| hdr_err | output | 1 | One-cycle pulse: header had a wrong word count |
| s_tvalid | input | 1 | Input byte valid |
| s_tready | output | 1 | Input byte accepted |
| s_tdata | input | 8 | Input byte |
| s_tlast | input | 1 | Final byte of input frame |
| m_tvalid | output | 1 | Output byte valid |
| m_tready | input | 1 | Output byte taken |
| m_tdata | output | 8 | Output byte |
| m_tlast | output | 1 | Final byte of output frame |
| tx_en | input | 1 | Transmit enable |
| jumbo_en | input | 1 | Allow oversize frames |
| vlan_en | input | 1 | Allow tagged-size frames |
| tx_done | output | 1 | One-cycle pulse per frame sent |
| tx_bytes | output | 64 | Running count of bytes sent |

## Verification
Each result has a fixed due cycle.
- `hdr_err` is due in the cycle after the edge that accepts the final header word, so the bench samples it at the next falling edge.
- `m_tvalid` is due two edges after the last input byte. FOLD takes one cycle, so the bench checks for low at the first falling edge and for high at the second.
- Output bytes are compared one by one against a queue, five nanoseconds before each rising edge at which `m_tvalid` and `m_tready` are both high. Random backpressure changes only at falling edges.
- `tx_done` and `tx_bytes` settle one edge after the final output handshake. The bench reads them only after the expected queue has drained and a few idle cycles have passed.

// File: rtl/txcs_pkg.sv
package txcs_pkg;
    localparam int OFF_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_SKIP,
        ST_FOLD,
        ST_SEND
    } txcs_state_t;

    typedef struct packed {
        logic             en;
        logic [OFF_W-1:0] start;
        logic [OFF_W-1:0] ins;
        logic [15:0]      seed;
    } txcs_hdr_t;
endpackage

// File: rtl/txcs_hdr_capture.sv
module txcs_hdr_capture
    import txcs_pkg::*;
#(
    parameter int HDR_WORDS = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        word_valid,
    input  logic        word_accept,
    input  logic [31:0] word_data,
    input  logic        word_last,
    input  logic        consume,
    output txcs_hdr_t   hdr,
    output logic        err
);
    localparam int CW = $clog2(HDR_WORDS + 1);

    logic [CW-1:0]    cnt;
    logic             st_en;
    logic [OFF_W-1:0] st_start;
    logic [OFF_W-1:0] st_ins;
    logic [15:0]      st_seed;
    logic             take;

    assign take = word_valid && word_accept;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            st_en    <= 1'b0;
            st_start <= '0;
            st_ins   <= '0;
            st_seed  <= '0;
            hdr      <= '0;
            err      <= 1'b0;
        end else begin
            err <= 1'b0;
            if (consume) hdr.en <= 1'b0;
            if (take) begin
                if (cnt == CW'(0)) st_en <= word_data[0];
                if (cnt == CW'(1)) begin
                    st_start <= word_data[31:16];
                    st_ins   <= word_data[15:0];
                end
                if (cnt == CW'(2)) st_seed <= word_data[15:0];
                if (word_last) begin
                    cnt <= '0;
                    if (cnt == CW'(HDR_WORDS - 1)) begin
                        hdr <= '{en: st_en, start: st_start, ins: st_ins, seed: st_seed};
                    end else begin
                        err    <= 1'b1;
                        hdr.en <= 1'b0;
                    end
                end else if (cnt != CW'(HDR_WORDS)) begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    // R1: an error pulse is always caused by a closing word one cycle earlier
    assert_err_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(word_valid && word_accept && word_last));
    // R1: word counter saturates at the header length
    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(HDR_WORDS));
endmodule

// File: rtl/txcs_sum_unit.sv
module txcs_sum_unit
    import txcs_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             first,
    input  logic [OFF_W-1:0] idx,
    input  logic [7:0]       data,
    input  logic [OFF_W-1:0] start,
    input  logic [15:0]      seed,
    output logic [15:0]      csum
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] contrib;
    logic             in_range;
    logic             low_half;
    logic [ACC_W-1:0] total;
    logic [16:0]      fold1;
    logic [15:0]      fold2;

    assign in_range = idx >= start;
    assign low_half = idx[0] ^ start[0];

    always_comb begin
        contrib = '0;
        if (in_range) begin
            if (low_half) contrib = ACC_W'(data);
            else          contrib = ACC_W'({data, 8'h00});
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc <= '0;
        else if (take) acc <= (first ? '0 : acc) + contrib;
    end

    assign total = acc + ACC_W'(seed);
    assign fold1 = {1'b0, total[15:0]} + {1'b0, total[31:16]};
    assign fold2 = fold1[15:0] + 16'(fold1[16]);
    assign csum  = ~fold2;

    // R3: accumulation within a frame never wraps
    assert_acc_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !first) |=> acc >= $past(acc));
endmodule

// File: rtl/txcs_frame_buf.sv
module txcs_frame_buf #(
    parameter int BUF_DEPTH = 4096,
    localparam int AW = $clog2(BUF_DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [BUF_DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/txcs_engine.sv
module txcs_engine
    import txcs_pkg::*;
#(
    parameter int BUF_DEPTH = 4096,
    parameter int HDR_WORDS = 5,
    parameter int STD_MAX   = 1518,
    parameter int TAG_MAX   = 1522
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hdr_valid,
    output logic        hdr_ready,
    input  logic [31:0] hdr_data,
    input  logic        hdr_last,
    output logic        hdr_err,
    input  logic        s_tvalid,
    output logic        s_tready,
    input  logic [7:0]  s_tdata,
    input  logic        s_tlast,
    output logic        m_tvalid,
    input  logic        m_tready,
    output logic [7:0]  m_tdata,
    output logic        m_tlast,
    input  logic        tx_en,
    input  logic        jumbo_en,
    input  logic        vlan_en,
    output logic        tx_done,
    output logic [63:0] tx_bytes
);
    localparam int AW    = $clog2(BUF_DEPTH);
    localparam int LEN_W = AW + 1;

    txcs_state_t      state_q, state_d;
    txcs_hdr_t        hdr;
    logic [LEN_W-1:0] wr_len;
    logic [AW-1:0]    rd_ptr;
    logic [15:0]      csum_q;
    logic [15:0]      sum_csum;
    logic [7:0]       rd_data;
    logic             in_take;
    logic             room;
    logic             at_end;
    logic             size_drop;
    logic             buf_we;
    logic [AW-1:0]    waddr;
    logic             consume;
    logic             out_take;

    assign in_take   = s_tvalid && s_tready;
    assign out_take  = m_tvalid && m_tready;
    assign room      = wr_len < LEN_W'(BUF_DEPTH);
    assign at_end    = LEN_W'(rd_ptr) == (wr_len - LEN_W'(1));
    assign size_drop = !jumbo_en && !vlan_en &&
                       (32'(wr_len) > STD_MAX) && (32'(wr_len) <= TAG_MAX);
    assign buf_we    = in_take && ((state_q == ST_IDLE && tx_en) ||
                                   (state_q == ST_FILL && room));
    assign waddr     = (state_q == ST_IDLE) ? '0 : wr_len[AW-1:0];

    txcs_hdr_capture #(.HDR_WORDS(HDR_WORDS)) u_hdr (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (hdr_valid),
        .word_accept(hdr_ready),
        .word_data  (hdr_data),
        .word_last  (hdr_last),
        .consume    (consume),
        .hdr        (hdr),
        .err        (hdr_err)
    );

    txcs_sum_unit #(.ACC_W(32)) u_sum (
        .clk  (clk),
        .rst_n(rst_n),
        .take (buf_we),
        .first(state_q == ST_IDLE),
        .idx  (OFF_W'(waddr)),
        .data (s_tdata),
        .start(hdr.start),
        .seed (hdr.seed),
        .csum (sum_csum)
    );

    txcs_frame_buf #(.BUF_DEPTH(BUF_DEPTH)) u_buf (
        .clk  (clk),
        .we   (buf_we),
        .waddr(waddr),
        .wdata(s_tdata),
        .raddr(rd_ptr),
        .rdata(rd_data)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        consume = 1'b0;
        unique case (state_q)
            ST_IDLE: if (in_take) begin
                if (!tx_en) begin
                    state_d = s_tlast ? ST_IDLE : ST_SKIP;
                    consume = s_tlast;
                end else begin
                    state_d = s_tlast ? ST_FOLD : ST_FILL;
                end
            end
            ST_FILL: if (in_take && s_tlast) state_d = ST_FOLD;
            ST_SKIP: if (in_take && s_tlast) begin
                state_d = ST_IDLE;
                consume = 1'b1;
            end
            ST_FOLD: begin
                state_d = size_drop ? ST_IDLE : ST_SEND;
                consume = size_drop;
            end
            ST_SEND: if (m_tready && at_end) begin
                state_d = ST_IDLE;
                consume = 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_len   <= '0;
            rd_ptr   <= '0;
            csum_q   <= '0;
            tx_done  <= 1'b0;
            tx_bytes <= '0;
        end else begin
            tx_done <= 1'b0;
            if (state_q == ST_IDLE && in_take && tx_en) wr_len <= LEN_W'(1);
            if (state_q == ST_FILL && in_take && room)  wr_len <= wr_len + LEN_W'(1);
            if (state_q == ST_FOLD) begin
                rd_ptr <= '0;
                csum_q <= sum_csum;
            end
            if (state_q == ST_SEND && m_tready) begin
                if (at_end) begin
                    tx_done  <= 1'b1;
                    tx_bytes <= tx_bytes + 64'(wr_len);
                end else begin
                    rd_ptr <= rd_ptr + AW'(1);
                end
            end
        end
    end

    // outputs
    always_comb begin
        hdr_ready = (state_q == ST_IDLE);
        s_tready  = (state_q == ST_IDLE && !hdr_valid) ||
                    (state_q == ST_FILL) || (state_q == ST_SKIP);
        m_tvalid  = (state_q == ST_SEND);
        m_tlast   = (state_q == ST_SEND) && at_end;
        m_tdata   = rd_data;
        if (hdr.en && (17'(rd_ptr) == 17'(hdr.ins)))
            m_tdata = csum_q[15:8];
        else if (hdr.en && (17'(rd_ptr) == 17'(hdr.ins) + 17'd1))
            m_tdata = csum_q[7:0];
    end

    // R9: output byte holds under backpressure
    assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));
    // R9: input and output phases never overlap
    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_tready && m_tvalid));
    // R8: completion is a single-cycle pulse following a final output handshake
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> ($past(out_take && m_tlast) && !$past(tx_done)));
    // R8: byte counter advances with every completion
    assert_bytes_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (tx_bytes > $past(tx_bytes)));
    // R10: stored length never exceeds the buffer
    assert_len_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_len <= LEN_W'(BUF_DEPTH));
endmodule

// File: tb/tb_txcs_engine.sv
`timescale 1ns/1ps
module tb_txcs_engine;
    localparam int DEPTH = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_valid = 1'b0, hdr_last = 1'b0;
    logic [31:0] hdr_data = '0;
    logic        hdr_ready, hdr_err;
    logic        s_tvalid = 1'b0, s_tlast = 1'b0;
    logic [7:0]  s_tdata = '0;
    logic        s_tready;
    logic        m_tvalid, m_tlast;
    logic [7:0]  m_tdata;
    logic        m_tready = 1'b1;
    logic        tx_en = 1'b1, jumbo_en = 1'b0, vlan_en = 1'b0;
    logic        tx_done;
    logic [63:0] tx_bytes;

    int checks = 0, fails = 0, done_cnt = 0;
    logic [8:0]  exp_q[$];
    logic [7:0]  fr  [0:4199];
    logic [7:0]  obuf[0:4199];
    bit          model_en = 0;
    int          model_st = 0, model_ins = 0;
    logic [15:0] model_seed = '0;
    longint      exp_bytes = 0;
    bit          bp_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    txcs_engine dut (
        .clk(clk), .rst_n(rst_n),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_data(hdr_data),
        .hdr_last(hdr_last), .hdr_err(hdr_err),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata), .s_tlast(s_tlast),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast),
        .tx_en(tx_en), .jumbo_en(jumbo_en), .vlan_en(vlan_en),
        .tx_done(tx_done), .tx_bytes(tx_bytes)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // backpressure source
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        m_tready = bp_mode ? lfsr[0] : 1'b1;
    end

    // monitor: scoreboard comparison
    bit     frame_bad = 0;
    logic [8:0] bad_act, bad_exp;
    always begin
        @(negedge clk);
        #5;
        if (tx_done) done_cnt++;
        if (m_tvalid && m_tready) begin
            if (exp_q.size() == 0) begin
                chk(0, "R6/R7", "unexpected output byte", {m_tlast, m_tdata}, 0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                if ({m_tlast, m_tdata} !== e && !frame_bad) begin
                    frame_bad = 1;
                    bad_act = {m_tlast, m_tdata};
                    bad_exp = e;
                end
                if (e[8]) begin
                    chk(!frame_bad, "R3/R4", "frame contents {last,byte}", bad_act, bad_exp);
                    frame_bad = 0;
                end
            end
        end
    end

    function automatic logic [15:0] ref_csum(input int n, input int st, input logic [15:0] seed);
        longint acc;
        acc = longint'(seed);
        for (int i = st; i < n; i++)
            acc += (((i - st) % 2) == 0) ? (longint'(fr[i]) << 8) : longint'(fr[i]);
        while ((acc >> 16) != 0) acc = (acc & 64'hFFFF) + (acc >> 16);
        return ~acc[15:0];
    endfunction

    task automatic put_hdr_word(input logic [31:0] w, input bit last);
        @(negedge clk);
        hdr_valid = 1'b1; hdr_data = w; hdr_last = last;
        #1;
        while (!hdr_ready) begin @(negedge clk); #1; end
        @(posedge clk);
    endtask

    task automatic send_hdr(input int nw, input logic [31:0] w0, input logic [31:0] w1,
                            input logic [31:0] w2);
        for (int k = 0; k < nw; k++)
            put_hdr_word(k == 0 ? w0 : k == 1 ? w1 : k == 2 ? w2 : 32'hA5A50000 + k,
                         k == nw - 1);
        @(negedge clk);
        hdr_valid = 1'b0; hdr_last = 1'b0;
        chk(hdr_err == (nw != 5), "R1", "hdr_err after last word", hdr_err, nw != 5);
        @(negedge clk);
        chk(hdr_err == 1'b0, "R1", "hdr_err single cycle", hdr_err, 0);
        if (nw == 5) begin
            model_en   = w0[0];
            model_st   = int'(w1[31:16]);
            model_ins  = int'(w1[15:0]);
            model_seed = w2[15:0];
        end else begin
            model_en = 0;
        end
    endtask

    task automatic put_byte(input logic [7:0] b, input bit last);
        @(negedge clk);
        s_tvalid = 1'b1; s_tdata = b; s_tlast = last;
        #1;
        while (!s_tready) begin @(negedge clk); #1; end
        @(posedge clk);
    endtask

    task automatic fill(input int len, input int pat);
        for (int i = 0; i < len; i++) fr[i] = 8'((i * 7 + pat) & 8'hFF);
    endtask

    task automatic run_frame(input int len, input bit send, input string req, input bit lat_chk);
        int n, d0;
        logic [15:0] c;
        n = (len > DEPTH) ? DEPTH : len;
        d0 = done_cnt;
        if (send) begin
            for (int i = 0; i < n; i++) obuf[i] = fr[i];
            if (model_en && tx_en) begin
                c = ref_csum(n, model_st, model_seed);
                if (model_ins < n)     obuf[model_ins]     = c[15:8];
                if (model_ins + 1 < n) obuf[model_ins + 1] = c[7:0];
            end
            for (int i = 0; i < n; i++) exp_q.push_back({i == n - 1, obuf[i]});
        end
        for (int i = 0; i < len; i++) put_byte(fr[i], i == len - 1);
        @(negedge clk);
        s_tvalid = 1'b0; s_tlast = 1'b0;
        if (lat_chk) begin
            chk(m_tvalid == 1'b0, "R9", "m_tvalid one edge after last input", m_tvalid, 0);
            @(negedge clk);
            chk(m_tvalid == 1'b1, "R9", "m_tvalid two edges after last input", m_tvalid, 1);
        end
        while (exp_q.size() != 0) @(posedge clk);
        repeat (4) @(posedge clk);
        @(negedge clk);
        if (send) exp_bytes += n;
        chk(done_cnt - d0 == (send ? 1 : 0), req, "tx_done pulses", done_cnt - d0, send ? 1 : 0);
        chk(tx_bytes == 64'(exp_bytes), req, "tx_bytes", tx_bytes, exp_bytes);
        model_en = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(m_tvalid == 0, "R11", "m_tvalid", m_tvalid, 0);
        chk(tx_done == 0,  "R11", "tx_done", tx_done, 0);
        chk(tx_bytes == 0, "R11", "tx_bytes", tx_bytes, 0);
        chk(hdr_ready == 1, "R11", "hdr_ready", hdr_ready, 1);
        chk(s_tready == 1, "R11", "s_tready", s_tready, 1);
        chk(hdr_err == 0,  "R11", "hdr_err", hdr_err, 0);

        // R8 plain frame, latency check R9
        fill(64, 3); run_frame(64, 1, "R8", 1);

        // R2 R3 R4 even region with seed, backpressure
        bp_mode = 1;
        send_hdr(5, 32'h1, {16'd14, 16'd24}, 32'h0000_1234);
        fill(60, 11); run_frame(60, 1, "R2", 0);
        // R3 odd region
        send_hdr(5, 32'h1, {16'd15, 16'd40}, 32'h0000_00FF);
        fill(61, 90); run_frame(61, 1, "R3", 0);
        // R4 insertion before start
        send_hdr(5, 32'h1, {16'd20, 16'd2}, 32'h0000_8001);
        fill(50, 200); run_frame(50, 1, "R4", 0);
        // R4 insertion at last byte: low byte falls past the end
        send_hdr(5, 32'h1, {16'd0, 16'd39}, 32'h0);
        fill(40, 5); run_frame(40, 1, "R4", 0);
        // R5 no new header: unchanged
        fill(40, 5); run_frame(40, 1, "R5", 0);
        // R2 enable bit clear: unchanged
        send_hdr(5, 32'h0, {16'd0, 16'd4}, 32'h0);
        fill(30, 9); run_frame(30, 1, "R2", 0);
        // R3 zero result written as 0x0000
        send_hdr(5, 32'h1, {16'd0, 16'd0}, 32'h0);
        fr[0] = 8'hFF; fr[1] = 8'hFF; fr[2] = 8'h00; fr[3] = 8'h00;
        run_frame(4, 1, "R3", 0);
        // R1 short and long headers rejected
        send_hdr(4, 32'h1, {16'd0, 16'd0}, 32'h0);
        fill(20, 1); run_frame(20, 1, "R1", 0);
        send_hdr(6, 32'h1, {16'd0, 16'd0}, 32'h0);
        fill(20, 2); run_frame(20, 1, "R1", 0);
        bp_mode = 0;

        // R6 transmit disabled
        tx_en = 1'b0;
        send_hdr(5, 32'h1, {16'd0, 16'd0}, 32'h0);
        fill(100, 4); run_frame(100, 0, "R6", 0);
        tx_en = 1'b1;
        fill(16, 6); run_frame(16, 1, "R6", 0);

        // R7 length rule
        fill(1520, 7); run_frame(1520, 0, "R7", 0);
        vlan_en = 1'b1; run_frame(1520, 1, "R7", 0); vlan_en = 1'b0;
        jumbo_en = 1'b1; fill(1522, 8); run_frame(1522, 1, "R7", 0); jumbo_en = 1'b0;
        fill(1523, 9); run_frame(1523, 1, "R7", 0);
        fill(1518, 10); run_frame(1518, 1, "R7", 0);

        // R10 truncation
        fill(4100, 12); run_frame(4100, 1, "R10", 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule